// File: doc/BRIEF.md
# Address-Latched Multicart Bank Mapper

This block is the bank-switching controller of an 8-bit console multicart. It never looks at the data bus. Any CPU write that lands in ROM space, meaning address bit 15 is high, stores part of the address bus as configuration. Two registers share that space, and address bit 14 picks between them. From the stored state the block works out three things combinationally: the 16 KB program-ROM bank shown in the lower window ($8000-$BFFF), the bank shown in the upper window ($C000-$FFFF), and an 8 KB character-ROM bank. It also drives a nametable mirroring select.

A 4-bit menu-select value acts like a jumper setting. In one mode it replaces the low nibble of the address sent to program ROM, and each soft reset advances it by one. The parameter `LARGE_BANKS` chooses the board variant:

- **Small-bank variant:** the auxiliary write sets the character bank.
- **Large-bank variant:** the auxiliary write sets a 2-bit outer bank, worth eight 16 KB banks per step, and the character bank stays at zero.

Top module: `addr_latch_mapper`

## Requirements
- R1: A write is accepted only when `wr_en` is high and `cpu_addr[15]` is high. An accepted write with `cpu_addr[14]` high loads the layout mode from `cpu_addr[5:4]` and the 3-bit program bank from `cpu_addr[2:0]`.
- R2: An accepted write with `cpu_addr[14]` low does two things:
  - It sets `mirror_sel` to the inverse of `cpu_addr[5]`.
  - It loads `cpu_addr[2:0]` into `chr_bank` (small-bank variant), or loads `cpu_addr[1:0]` into the outer bank (large-bank variant). In the large-bank variant the outer bank supplies bits 4:3 of each window bank.
- R3: A write strobe with `cpu_addr[15]` low, or address activity with `wr_en` low, leaves every output unchanged.
- R4: In modes 0 and 1, the lower window is bank outer*8+prg and the upper window is fixed at outer*8+7.
- R5: In mode 2, the two windows form one 32 KB bank. The lower window is (outer*8+prg) with bit 0 cleared, and the upper window is the same value with bit 0 set.
- R6: In mode 3, both windows show bank outer*8+prg.
- R7: In mode 1, `rom_addr` is `cpu_addr` with bits 3:0 replaced by the menu-select value. In every other mode, `rom_addr` equals `cpu_addr`.
- R8: A soft reset clears the mode and the outer bank and advances the menu-select value by one, wrapping from 15 to 0. It leaves the program bank, the character bank and the mirroring select as they were.
- R9: Power-on reset sets the following:
  - mode, program bank, outer bank, character bank and mirroring all to zero;
  - the menu-select value to 13 in the small-bank variant, or 6 in the large-bank variant.
- R10: When a soft reset and a write occur in the same cycle, the soft reset wins and the write is dropped.
- R11: In the large-bank variant, `chr_bank` is always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| soft_rst | input | 1 | Soft reset pulse, synchronous, one cycle per reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address bus |
| rom_addr | output | 16 | Address presented to program ROM |
| prg_win_lo | output | 5 | 16 KB bank for $8000-$BFFF |
| prg_win_hi | output | 5 | 16 KB bank for $C000-$FFFF |
| chr_bank | output | 3 | 8 KB character-ROM bank |
| mirror_sel | output | 1 | Nametable mirroring select |

## Verification
The assertions assume a few things about the inputs:
- `soft_rst` is a synchronous pulse.
- `cpu_addr` is stable around the clock edge on which `wr_en` is sampled.
- Combinational checks of `rom_addr` are meaningful only while `cpu_addr` holds a read address.

The bench drives every input on the falling clock edge and holds it for a full cycle. It lowers `wr_en` before it reads back outputs, and it only ever raises `soft_rst` together with a write on purpose, in the one test aimed at R10. Both variants run side by side from the same stimulus, sweeping every mode, program bank and outer bank.

// File: rtl/amap_pkg.sv
package amap_pkg;

  localparam int OUTER_W = 2;
  localparam int PRG_W   = 3;
  localparam int BANK_W  = OUTER_W + PRG_W;
  localparam int CHR_W   = 3;
  localparam int SW_W    = 4;

  typedef enum logic [1:0] {
    MODE_SPLIT  = 2'd0,
    MODE_MENU   = 2'd1,
    MODE_WIDE   = 2'd2,
    MODE_MIRROR = 2'd3
  } amap_mode_e;

  // lower 16 KB window bank
  function automatic logic [BANK_W-1:0] f_win_lo(amap_mode_e m,
                                                 logic [OUTER_W-1:0] o,
                                                 logic [PRG_W-1:0] p);
    logic [BANK_W-1:0] b;
    b = {o, p};
    if (m == MODE_WIDE) f_win_lo = {b[BANK_W-1:1], 1'b0};
    else                f_win_lo = b;
  endfunction

  // upper 16 KB window bank
  function automatic logic [BANK_W-1:0] f_win_hi(amap_mode_e m,
                                                 logic [OUTER_W-1:0] o,
                                                 logic [PRG_W-1:0] p);
    logic [BANK_W-1:0] b;
    b = {o, p};
    case (m)
      MODE_SPLIT, MODE_MENU: f_win_hi = {o, {PRG_W{1'b1}}};
      MODE_WIDE:             f_win_hi = {b[BANK_W-1:1], 1'b1};
      default:               f_win_hi = b;
    endcase
  endfunction

  // program ROM read address with optional menu nibble overlay
  function automatic logic [15:0] f_rd_addr(amap_mode_e m, logic [15:0] a,
                                            logic [SW_W-1:0] sw);
    if (m == MODE_MENU) f_rd_addr = {a[15:SW_W], sw};
    else                f_rd_addr = a;
  endfunction

endpackage

// File: rtl/amap_cfg_regs.sv
module amap_cfg_regs
  import amap_pkg::*;
#(
  parameter bit LARGE_BANKS = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               wr_cfg,
  input  logic               wr_aux,
  input  logic [1:0]         fld_mode,
  input  logic               fld_mir,
  input  logic [PRG_W-1:0]   fld_lo,
  output amap_mode_e         mode_q,
  output logic [PRG_W-1:0]   prg_q,
  output logic [OUTER_W-1:0] outer_q,
  output logic [CHR_W-1:0]   chr_q,
  output logic               mirror_q
);

  // mode and program bank: soft reset clears mode only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SPLIT;
      prg_q  <= '0;
    end else if (soft_rst) begin
      mode_q <= MODE_SPLIT;
    end else if (wr_cfg) begin
      mode_q <= amap_mode_e'(fld_mode);
      prg_q  <= fld_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  mirror_q <= 1'b0;
    else if (wr_aux && !soft_rst) mirror_q <= ~fld_mir;
  end

  generate
    if (LARGE_BANKS) begin : g_large
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       outer_q <= '0;
        else if (soft_rst) outer_q <= '0;
        else if (wr_aux)  outer_q <= fld_lo[OUTER_W-1:0];
      end
      assign chr_q = '0;
    end else begin : g_small
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  chr_q <= '0;
        else if (wr_aux && !soft_rst) chr_q <= fld_lo[CHR_W-1:0];
      end
      assign outer_q = '0;
    end
  endgenerate

endmodule

// File: rtl/amap_menu_sw.sv
module amap_menu_sw
  import amap_pkg::*;
#(
  parameter logic [SW_W-1:0] INIT = 4'hD
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  output logic [SW_W-1:0] sw_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sw_q <= INIT;
    else if (soft_rst) sw_q <= sw_q + 1'b1;
  end

endmodule

// File: rtl/amap_prg_map.sv
module amap_prg_map
  import amap_pkg::*;
(
  input  amap_mode_e         mode,
  input  logic [OUTER_W-1:0] outer,
  input  logic [PRG_W-1:0]   prg,
  output logic [BANK_W-1:0]  win_lo,
  output logic [BANK_W-1:0]  win_hi
);

  always_comb begin
    win_lo = f_win_lo(mode, outer, prg);
    win_hi = f_win_hi(mode, outer, prg);
  end

endmodule

// File: rtl/amap_rd_addr.sv
module amap_rd_addr
  import amap_pkg::*;
(
  input  amap_mode_e      mode,
  input  logic [15:0]     addr,
  input  logic [SW_W-1:0] sw,
  output logic [15:0]     rd_addr
);

  always_comb rd_addr = f_rd_addr(mode, addr, sw);

endmodule

// File: rtl/addr_latch_mapper.sv
module addr_latch_mapper
  import amap_pkg::*;
#(
  parameter bit LARGE_BANKS = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [15:0]       cpu_addr,
  output logic [15:0]       rom_addr,
  output logic [BANK_W-1:0] prg_win_lo,
  output logic [BANK_W-1:0] prg_win_hi,
  output logic [CHR_W-1:0]  chr_bank,
  output logic              mirror_sel
);

  localparam int ROM_BIT = 15;
  localparam int SEL_BIT = 14;
  localparam logic [SW_W-1:0] SW_INIT = LARGE_BANKS ? 4'h6 : 4'hD;

  // named internal events
  logic wr_hit, wr_cfg, wr_aux;
  assign wr_hit = wr_en && cpu_addr[ROM_BIT];
  assign wr_cfg = wr_hit && cpu_addr[SEL_BIT];
  assign wr_aux = wr_hit && !cpu_addr[SEL_BIT];

  amap_mode_e         mode_q;
  logic [PRG_W-1:0]   prg_q;
  logic [OUTER_W-1:0] outer_q;
  logic [SW_W-1:0]    sw_q;

  amap_cfg_regs #(.LARGE_BANKS(LARGE_BANKS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .wr_cfg   (wr_cfg),
    .wr_aux   (wr_aux),
    .fld_mode (cpu_addr[5:4]),
    .fld_mir  (cpu_addr[5]),
    .fld_lo   (cpu_addr[PRG_W-1:0]),
    .mode_q   (mode_q),
    .prg_q    (prg_q),
    .outer_q  (outer_q),
    .chr_q    (chr_bank),
    .mirror_q (mirror_sel)
  );

  amap_menu_sw #(.INIT(SW_INIT)) u_sw (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .sw_q     (sw_q)
  );

  amap_prg_map u_map (
    .mode   (mode_q),
    .outer  (outer_q),
    .prg    (prg_q),
    .win_lo (prg_win_lo),
    .win_hi (prg_win_hi)
  );

  amap_rd_addr u_rd (
    .mode    (mode_q),
    .addr    (cpu_addr),
    .sw      (sw_q),
    .rd_addr (rom_addr)
  );

endmodule

// File: rtl/amap_checker.sv
module amap_checker
  import amap_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               soft_rst,
  input logic               wr_en,
  input logic               wr_cfg,
  input logic [15:0]        cpu_addr,
  input logic [1:0]         mode_q,
  input logic [PRG_W-1:0]   prg_q,
  input logic [OUTER_W-1:0] outer_q,
  input logic [SW_W-1:0]    sw_q,
  input logic [15:0]        rom_addr,
  input logic [BANK_W-1:0]  prg_win_lo,
  input logic [BANK_W-1:0]  prg_win_hi
);

  assert_cfg_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && !soft_rst) |=> (mode_q == $past(cpu_addr[5:4]) && prg_q == $past(cpu_addr[2:0])));

  assert_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && cpu_addr[15]) && !soft_rst) |=> ($stable(mode_q) && $stable(prg_q) && $stable(outer_q)));

  assert_fixed_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1] == 1'b0) |-> (prg_win_hi == {outer_q, {PRG_W{1'b1}}}));

  assert_wide_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd2) |-> (prg_win_lo[0] == 1'b0 && prg_win_hi == prg_win_lo + 1'b1));

  assert_same_win_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd3) |-> (prg_win_lo == prg_win_hi));

  assert_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'd1) |-> (rom_addr == cpu_addr));

  assert_menu_nib_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd1) |-> (rom_addr[3:0] == sw_q && rom_addr[15:4] == cpu_addr[15:4]));

  assert_soft_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (mode_q == 2'd0 && outer_q == '0 && sw_q == SW_W'($past(sw_q) + 1'b1)));

  assert_sw_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> $stable(sw_q));

  assert_soft_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> $stable(prg_q));

endmodule

bind addr_latch_mapper amap_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst   (soft_rst),
  .wr_en      (wr_en),
  .wr_cfg     (wr_cfg),
  .cpu_addr   (cpu_addr),
  .mode_q     (mode_q),
  .prg_q      (prg_q),
  .outer_q    (outer_q),
  .sw_q       (sw_q),
  .rom_addr   (rom_addr),
  .prg_win_lo (prg_win_lo),
  .prg_win_hi (prg_win_hi)
);

// File: tb/addr_latch_mapper_tb.sv
module addr_latch_mapper_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] cpu_addr = 16'h0;

  logic [15:0] ra_s, ra_l;
  logic [4:0]  lo_s, hi_s, lo_l, hi_l;
  logic [2:0]  chr_s, chr_l;
  logic        mir_s, mir_l;

  int checks = 0;
  int fails  = 0;
  int sw_s, sw_l;

  always #5 clk = ~clk;

  addr_latch_mapper #(.LARGE_BANKS(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .cpu_addr(cpu_addr), .rom_addr(ra_s), .prg_win_lo(lo_s),
    .prg_win_hi(hi_s), .chr_bank(chr_s), .mirror_sel(mir_s));

  addr_latch_mapper #(.LARGE_BANKS(1'b1)) u_dut_lg (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .cpu_addr(cpu_addr), .rom_addr(ra_l), .prg_win_lo(lo_l),
    .prg_win_hi(hi_l), .chr_bank(chr_l), .mirror_sel(mir_l));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int e_lo(int m, int o, int p);
    int b = o * 8 + p;
    return (m == 2) ? (b / 2) * 2 : b;
  endfunction

  function automatic int e_hi(int m, int o, int p);
    int b = o * 8 + p;
    if (m < 2)  return o * 8 + 7;
    if (m == 2) return (b / 2) * 2 + 1;
    return b;
  endfunction

  task automatic do_write(input logic [15:0] a);
    @(negedge clk);
    wr_en = 1'b1; cpu_addr = a;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_soft();
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    sw_s = (sw_s + 1) % 16;
    sw_l = (sw_l + 1) % 16;
  endtask

  // puts both units in mode 1 with program bank p and checks the menu nibble
  task automatic check_sw(input string tag, input int p);
    do_write(16'hC010 | 16'(p));
    cpu_addr = 16'h9E55;
    #1;
    chk({tag, " small menu"}, int'(ra_s), 'h9E50 | sw_s);
    chk({tag, " large menu"}, int'(ra_l), 'h9E50 | sw_l);
  endtask

  task automatic power_on();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sw_s = 13; sw_l = 6;
    cpu_addr = 16'h1234;
    #1;
    chk("R9 small lo", int'(lo_s), 0);
    chk("R9 small hi", int'(hi_s), 7);
    chk("R9 large lo", int'(lo_l), 0);
    chk("R9 large hi", int'(hi_l), 7);
    chk("R9 small chr", int'(chr_s), 0);
    chk("R9 mirror", int'(mir_s) + int'(mir_l), 0);
    chk("R9 pass-through", int'(ra_s), 'h1234);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    power_on();
    check_sw("R9 R7 init", 0);

    // sweep outer bank, mode and program bank (R1 R2 R4 R5 R6 R7 R11)
    for (int o = 0; o < 4; o++) begin
      for (int m = 0; m < 4; m++) begin
        for (int p = 0; p < 8; p++) begin
          do_write(16'h8000 | 16'((p % 2) << 5) | 16'(o));
          do_write(16'hC000 | 16'(m << 4) | 16'(p));
          cpu_addr = 16'hF3A7;
          #1;
          chk("R1 R4 R5 R6 small lo", int'(lo_s), e_lo(m, 0, p));
          chk("R1 R4 R5 R6 small hi", int'(hi_s), e_hi(m, 0, p));
          chk("R2 R4 R5 R6 large lo", int'(lo_l), e_lo(m, o, p));
          chk("R2 R4 R5 R6 large hi", int'(hi_l), e_hi(m, o, p));
          chk("R2 small chr", int'(chr_s), o);
          chk("R11 large chr", int'(chr_l), 0);
          chk("R2 mirror small", int'(mir_s), 1 - (p % 2));
          chk("R2 mirror large", int'(mir_l), 1 - (p % 2));
          chk("R7 small rd", int'(ra_s), (m == 1) ? ('hF3A0 | sw_s) : 'hF3A7);
          chk("R7 large rd", int'(ra_l), (m == 1) ? ('hF3A0 | sw_l) : 'hF3A7);
        end
      end
    end

    // full character bank range (R2)
    for (int c = 0; c < 8; c++) begin
      do_write(16'h8020 | 16'(c));
      #1;
      chk("R2 chr sweep", int'(chr_s), c);
      chk("R11 chr sweep large", int'(chr_l), 0);
      chk("R2 mirror cleared", int'(mir_s), 0);
    end

    // ignored writes (R3): state is mode 3, prg 7, outer 3 (large)
    do_write(16'h4035);
    do_write(16'h0000);
    @(negedge clk);
    cpu_addr = 16'hC012;
    @(negedge clk);
    #1;
    chk("R3 small lo", int'(lo_s), 7);
    chk("R3 small hi", int'(hi_s), 7);
    chk("R3 large lo", int'(lo_l), 31);
    chk("R3 chr", int'(chr_s), 7);
    chk("R3 rd", int'(ra_s), 'hC012);

    // soft reset (R8)
    do_write(16'h8002);
    do_write(16'hC035);
    do_soft();
    cpu_addr = 16'h8ABC;
    #1;
    chk("R8 small lo", int'(lo_s), 5);
    chk("R8 small hi", int'(hi_s), 7);
    chk("R8 large lo", int'(lo_l), 5);
    chk("R8 large hi", int'(hi_l), 7);
    chk("R8 chr kept", int'(chr_s), 2);
    chk("R8 mirror kept", int'(mir_s), 1);
    chk("R8 mode cleared rd", int'(ra_s), 'h8ABC);
    check_sw("R8 first", 5);
    for (int k = 0; k < 17; k++) begin
      do_soft();
      check_sw("R8 wrap", k % 8);
    end

    // soft reset and write in the same cycle (R10)
    do_write(16'hC036);
    @(negedge clk);
    soft_rst = 1'b1; wr_en = 1'b1; cpu_addr = 16'hC011;
    @(negedge clk);
    soft_rst = 1'b0; wr_en = 1'b0;
    sw_s = (sw_s + 1) % 16;
    sw_l = (sw_l + 1) % 16;
    cpu_addr = 16'hBEEF;
    #1;
    chk("R10 small lo", int'(lo_s), 6);
    chk("R10 small hi", int'(hi_s), 7);
    chk("R10 rd", int'(ra_s), 'hBEEF);
    check_sw("R10 sw", 6);

    // power-on again restores the initial menu value (R9)
    power_on();
    check_sw("R9 again", 3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule